// File: doc/BRIEF.md
# Two-Wire Slave Address Front End with Internal Target Routing

This block sits on a two-wire serial bus (clock line plus open-drain data line) as a slave. It brings both lines into the system clock domain, finds START and STOP conditions, and shifts in the first byte after every START as the slave address. The upper nibble of that byte must carry the fixed device type. A three-bit field then picks one of three internal targets: a memory array, a control/status register, or a bank of potentiometer wiper registers. The lowest bit gives the direction of the transfer.

When the address matches, the block acknowledges it, raises a select line for the chosen target and reports the direction. In a write, each data byte that follows is acknowledged and handed to the target with a one-cycle strobe and its position after the address. Writes to the memory array and to the wiper bank need an external write-enable latch to be set. Without it, the block withholds the acknowledge and produces no strobe. A byte that is refused, or an address that does not match, makes the block ignore the bus until the next START or STOP. In a read, the front end acknowledges only the address. It does not drive the data that follows.

Top module: `tw_subtarget_slave`

## Requirements
- R1: After reset the data line is released (`sda_pull` = 0), all three selects are low, `rd_dir` is 0 and `byte_valid` is low.
- R2: An address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 are a valid selector. The acknowledge holds the data line low during the 9th clock pulse. `sda_pull` changes only while the clock line is low.
- R3: Selector field bits 3..1 are decoded as follows: 000 gives `sel_mem`, 010 gives `sel_ctl` and 111 gives `sel_pot`. Every other value selects nothing. At most one select is high, and it stays high from the address acknowledge until STOP or START.
- R4: Address bit 0 is the direction: 1 sets `rd_dir` (read) and 0 clears it (write).
- R5: While `wr_en` is 0, a write addressed to the memory or wiper target gets no acknowledge and raises no select. A data byte for those targets gets no acknowledge and no `byte_valid` strobe. Control-register writes do not depend on `wr_en`.
- R6: In a write, each data byte is shifted in MSB first, acknowledged, and strobed once on `byte_valid` with its value on `byte_data`. `byte_idx` is 0 for the first byte after the address. At most MAX_BYTES (default 2) data bytes are accepted; a further byte gets no acknowledge and no strobe.
- R7: After a non-matching address, the following bytes get no acknowledge and no strobe until the next START or STOP.
- R8: STOP returns the block to idle: the selects drop and the data line is released.
- R9: A repeated START in the middle of a transaction begins a new address phase, with no STOP, and decodes the new address.
- R10: In a read, no `byte_valid` strobe is produced and the data line stays released after the address acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| wr_en | input | 1 | Write-enable latch state; gates memory and wiper writes |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain driver enable) |
| sel_mem | output | 1 | Memory array target selected |
| sel_ctl | output | 1 | Control/status register target selected |
| sel_pot | output | 1 | Wiper register bank target selected |
| rd_dir | output | 1 | Direction of the current transaction, 1 = read |
| byte_valid | output | 1 | One-cycle strobe for an accepted write data byte |
| byte_data | output | 8 | Value of the accepted data byte |
| byte_idx | output | $clog2(MAX_BYTES+1) | Position of the byte after the address, from 0 |

## Verification
The assertions assume that the bus clock stays at each level for many system clocks, so that the two-flop synchroniser never misses an edge. They also assume that the master changes the data line only while the clock is low, except when it makes START and STOP. Under those conditions the pull-enable edges fall in clock-low time, and the wiper and memory strobes appear only while the latch is set. The bench's master holds each half bit for eight system clocks and moves its data line at the middle of the clock-low phase. The bus is modelled as wired-AND, so the acknowledge seen by the master is the one the slave drives.

// File: rtl/tw_subtarget_slave.sv
module tw_subtarget_slave #(
  parameter int          MAX_BYTES = 2,
  parameter logic [3:0]  DEV_TYPE  = 4'b1010
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               scl_in,
  input  logic                               sda_in,
  input  logic                               wr_en,
  output logic                               sda_pull,
  output logic                               sel_mem,
  output logic                               sel_ctl,
  output logic                               sel_pot,
  output logic                               rd_dir,
  output logic                               byte_valid,
  output logic [7:0]                         byte_data,
  output logic [$clog2(MAX_BYTES+1)-1:0]     byte_idx
);
  localparam int IW = $clog2(MAX_BYTES+1);
  localparam logic [2:0] TGT_MEM = 3'b000;
  localparam logic [2:0] TGT_CTL = 3'b010;
  localparam logic [2:0] TGT_POT = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_ACK, S_READ, S_SKIP} state_t;

  state_t      st, after_ack;
  logic [2:0]  scl_q, sda_q;
  logic [7:0]  shreg;
  logic [3:0]  bit_cnt;
  logic [IW-1:0] idx;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];

  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire byte_end = scl_fall && (bit_cnt == 4'd8);

  wire [2:0] tgt   = shreg[3:1];
  wire hit_mem     = (tgt == TGT_MEM);
  wire hit_ctl     = (tgt == TGT_CTL);
  wire hit_pot     = (tgt == TGT_POT);
  wire addr_gated  = ~shreg[0] & (hit_mem | hit_pot) & ~wr_en;
  wire addr_ok     = (shreg[7:4] == DEV_TYPE) & (hit_mem | hit_ctl | hit_pot) & ~addr_gated;
  wire data_ok     = (int'(idx) < MAX_BYTES) & ~((sel_mem | sel_pot) & ~wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      after_ack  <= S_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      idx        <= '0;
      sda_pull   <= 1'b0;
      sel_mem    <= 1'b0;
      sel_ctl    <= 1'b0;
      sel_pot    <= 1'b0;
      rd_dir     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_idx   <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (start_c || stop_c) begin
        st       <= start_c ? S_ADDR : S_IDLE;
        bit_cnt  <= '0;
        idx      <= '0;
        sda_pull <= 1'b0;
        sel_mem  <= 1'b0;
        sel_ctl  <= 1'b0;
        sel_pot  <= 1'b0;
        rd_dir   <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              if (st == S_ADDR) begin
                if (addr_ok) begin
                  sda_pull  <= 1'b1;
                  sel_mem   <= hit_mem;
                  sel_ctl   <= hit_ctl;
                  sel_pot   <= hit_pot;
                  rd_dir    <= shreg[0];
                  after_ack <= shreg[0] ? S_READ : S_DATA;
                  st        <= S_ACK;
                end else begin
                  st <= S_SKIP;
                end
              end else if (data_ok) begin
                sda_pull   <= 1'b1;
                byte_valid <= 1'b1;
                byte_data  <= shreg;
                byte_idx   <= idx;
                idx        <= idx + 1'b1;
                after_ack  <= S_DATA;
                st         <= S_ACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              st       <= after_ack;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module tw_subtarget_slave_chk #(
  parameter int MAX_BYTES = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           scl_in,
  input logic                           wr_en,
  input logic                           sda_pull,
  input logic                           sel_mem,
  input logic                           sel_ctl,
  input logic                           sel_pot,
  input logic                           rd_dir,
  input logic                           byte_valid,
  input logic [$clog2(MAX_BYTES+1)-1:0] byte_idx
);
  // R3
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mem, sel_ctl, sel_pot}));

  // R2
  pull_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);

  // R2
  pull_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_in);

  // R5
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && (sel_mem || sel_pot)) |-> wr_en);

  // R10
  no_read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !rd_dir);

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (int'(byte_idx) < MAX_BYTES));

  // R6
  strobe_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (sel_mem || sel_ctl || sel_pot));

  // R6
  strobe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> sda_pull);
endmodule

bind tw_subtarget_slave tw_subtarget_slave_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (.*);

// File: tb/tw_subtarget_slave_bench.sv
module tw_subtarget_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_en = 1'b0;
  logic sda_pull, sel_mem, sel_ctl, sel_pot, rd_dir, byte_valid;
  logic [7:0] byte_data;
  logic [1:0] byte_idx;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  logic [7:0] last_data = '0;
  logic [1:0] last_idx = '0;
  logic pull_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_subtarget_slave u_tw_subtarget_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .wr_en(wr_en),
    .sda_pull(sda_pull), .sel_mem(sel_mem), .sel_ctl(sel_ctl), .sel_pot(sel_pot),
    .rd_dir(rd_dir), .byte_valid(byte_valid), .byte_data(byte_data), .byte_idx(byte_idx)
  );

  always @(posedge clk) begin
    if (byte_valid) begin
      strobes   <= strobes + 1;
      last_data <= byte_data;
      last_idx  <= byte_idx;
    end
    if (sda_pull) pull_seen <= 1'b1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HALF/2);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HALF/2);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(HALF/2);
      scl_m = 1'b1; wait_clk(HALF);
      scl_m = 1'b0; wait_clk(HALF/2);
    end
    sda_m = 1'b1; wait_clk(HALF/2);
    scl_m = 1'b1; wait_clk(HALF/2);
    ack = ~sda_line;
    wait_clk(HALF/2);
    scl_m = 1'b0; wait_clk(HALF/2);
  endtask

  // {addr[7:0], wr_en, ack, sel_mem, sel_ctl, sel_pot, rd_dir}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {8'hA0, 1'b1, 1'b1, 3'b100, 1'b0},
    {8'hA1, 1'b0, 1'b1, 3'b100, 1'b1},
    {8'hA4, 1'b0, 1'b1, 3'b010, 1'b0},
    {8'hA5, 1'b0, 1'b1, 3'b010, 1'b1},
    {8'hAE, 1'b1, 1'b1, 3'b001, 1'b0},
    {8'hAE, 1'b0, 1'b0, 3'b000, 1'b0},
    {8'hA0, 1'b0, 1'b0, 3'b000, 1'b0},
    {8'hAF, 1'b0, 1'b1, 3'b001, 1'b1},
    {8'hA2, 1'b1, 1'b0, 3'b000, 1'b0},
    {8'hAC, 1'b1, 1'b0, 3'b000, 1'b0},
    {8'hB0, 1'b1, 1'b0, 3'b000, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic ack;
    int s0;
    wait_clk(3);
    // R1
    chk(!sda_pull && !sel_mem && !sel_ctl && !sel_pot && !rd_dir && !byte_valid,
        "R1 reset state", {sda_pull, sel_mem, sel_ctl, sel_pot, rd_dir}, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R2 R3 R4 R5: address decode table
    for (int v = 0; v < NV; v++) begin
      wr_en = VEC[v][5];
      bus_start();
      send_byte(VEC[v][13:6], ack);
      chk(ack == VEC[v][4], "R2 address ack", ack, VEC[v][4]);
      chk({sel_mem, sel_ctl, sel_pot} == VEC[v][3:1], "R3 target select",
          {sel_mem, sel_ctl, sel_pot}, VEC[v][3:1]);
      chk(rd_dir == VEC[v][0], "R4 direction", rd_dir, VEC[v][0]);
      bus_stop();
      wait_clk(4);
      // R8
      chk({sel_mem, sel_ctl, sel_pot, sda_pull} == 4'b0, "R8 stop to idle",
          {sel_mem, sel_ctl, sel_pot, sda_pull}, 0);
    end

    // R6: memory write, two bytes then one excess
    wr_en = 1'b1;
    s0 = strobes;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h5C, ack);
    chk(ack, "R6 data byte 0 ack", ack, 1);
    chk(strobes == s0 + 1 && last_data == 8'h5C && last_idx == 2'd0,
        "R6 byte 0 strobe", {last_idx, last_data}, {2'd0, 8'h5C});
    send_byte(8'h93, ack);
    chk(strobes == s0 + 2 && last_data == 8'h93 && last_idx == 2'd1,
        "R6 byte 1 strobe", {last_idx, last_data}, {2'd1, 8'h93});
    send_byte(8'h11, ack);
    chk(!ack && strobes == s0 + 2, "R6 excess byte refused", {ack, strobes - s0}, {1'b0, 2});
    bus_stop();
    wait_clk(4);

    // R5: latch dropped before a wiper data byte
    bus_start();
    send_byte(8'hAE, ack);
    wr_en = 1'b0;
    s0 = strobes;
    send_byte(8'h42, ack);
    chk(!ack && strobes == s0, "R5 gated data byte", {ack, strobes - s0}, 0);
    bus_stop();
    wait_clk(4);

    // R5: control register write without latch
    bus_start();
    send_byte(8'hA4, ack);
    s0 = strobes;
    send_byte(8'h3C, ack);
    chk(ack && strobes == s0 + 1 && last_data == 8'h3C, "R5 ctl write ungated",
        {ack, last_data}, {1'b1, 8'h3C});
    bus_stop();
    wait_clk(4);

    // R7: mismatch ignores following bytes
    wr_en = 1'b1;
    bus_start();
    send_byte(8'hB4, ack);
    s0 = strobes;
    pull_seen = 1'b0;
    send_byte(8'hA0, ack);
    send_byte(8'h77, ack);
    chk(!pull_seen && strobes == s0, "R7 ignore after mismatch",
        {pull_seen, strobes - s0}, 0);
    bus_stop();
    wait_clk(4);

    // R9: repeated start re-decodes
    bus_start();
    send_byte(8'hA0, ack);
    sda_m = 1'b1; wait_clk(HALF/2);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(HALF/2);
    chk(!sel_mem, "R9 repeated start clears select", sel_mem, 0);
    send_byte(8'hAF, ack);
    chk(ack && sel_pot && rd_dir && !sel_mem, "R9 new address decoded",
        {sel_mem, sel_pot, rd_dir}, 3'b011);

    // R10: read phase releases line, no strobes
    s0 = strobes;
    pull_seen = 1'b0;
    send_byte(8'hFF, ack);
    chk(!pull_seen && strobes == s0, "R10 read no strobe no drive",
        {pull_seen, strobes - s0}, 0);
    bus_stop();
    wait_clk(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule